// File: doc/BRIEF.md
# ECC Error Reporting Controller

This block sits beside two ECC-protected memories, a RAM and a flash array, and turns their non-correctable error strobes into one interrupt request for software. Each source presents a one-cycle strobe together with the faulting address, bus attributes, the number of the bus master and the data word. Software sets one enable bit per source. An enabled event raises a status flag and snapshots its fault details into a capture set that belongs to that source. Events from a disabled source are dropped. They leave no trace.

The status register is kept strictly one-hot. It is modelled as a small state machine with three states: `FLG_NONE` (no flag), `FLG_RAM` (RAM flag) and `FLG_FLASH` (flash flag). The named transitions are:

- `T_SET_RAM`: any state to `FLG_RAM` on an enabled RAM event.
- `T_SET_FLASH`: any state to `FLG_FLASH` on an enabled flash event with no RAM event in the same cycle.
- `T_RELOAD`: a state to itself when a new event of the same kind arrives.
- `T_CLEAR`: `FLG_RAM` or `FLG_FLASH` to `FLG_NONE` on a software write-1 to the set flag, when no enabled event arrives in that cycle.

A newer event always replaces the older flag and reloads the capture set of its own source. The flag shown therefore always belongs to the freshest captured fault.

Software reaches the block through a byte-wide port. Reads are combinational; writes take effect on the clock edge.

Top module: `ecc_fault_reporter`

## Requirements
- R1: After reset, the configuration byte, the status byte and every capture register read 0, and `irq` is low.
- R2: Configuration byte (offset 0x00). Bit 1 enables RAM reporting and bit 0 enables flash reporting. Writes to bits 7..2 are dropped and those bits read 0.
- R3: An enabled RAM strobe has these effects:
  - The status byte reads exactly 0x02 after the next edge.
  - The RAM capture set is loaded: address at 0x04, info at 0x08, data at 0x0C.
  
  An enabled flash strobe has these effects:
  - The status byte reads exactly 0x01.
  - The flash capture set is loaded: address at 0x14, info at 0x18, data at 0x1C.
  - The other source's capture set is not changed.
- R4: The status byte never has more than one bit set. An enabled event clears the previous flag and sets its own in the same update.
- R5: A strobe from a source whose enable bit is 0 sets no flag and changes no capture register.
- R6: `irq` equals (bit 1 of the configuration byte AND bit 1 of the status byte) OR (bit 0 of the configuration byte AND bit 0 of the status byte).
- R7: Status offset 0x01 works as write-1-to-clear. Writing 1 to the set flag clears it at the next edge, and `irq` falls in that cycle. Writing 0, or writing 1 to a flag that is not set, has no effect.
- R8: When enabled RAM and flash strobes arrive in the same cycle, only the RAM flag is set and only the RAM capture set is loaded.
- R9: When an enabled event arrives in the same cycle as a clearing write, the event wins. Its flag is set after the edge.
- R10: Capture registers are 32-bit words read bytewise, little-endian: offset+0 holds bits 7..0. The info word holds the attributes in bits 7..0 and the master number from bit 8 upward. All other bits are 0. Software writes to capture offsets are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ram_err_strb | input | 1 | One-cycle RAM non-correctable error strobe |
| ram_err_addr | input | ADDR_W | RAM fault address |
| ram_err_attr | input | ATTR_W | RAM access attributes |
| ram_err_mid | input | MID_W | RAM bus master number |
| ram_err_data | input | DATA_W | RAM faulting data word |
| flash_err_strb | input | 1 | One-cycle flash non-correctable error strobe |
| flash_err_addr | input | ADDR_W | Flash fault address |
| flash_err_attr | input | ATTR_W | Flash access attributes |
| flash_err_mid | input | MID_W | Flash bus master number |
| flash_err_data | input | DATA_W | Flash faulting data word |
| reg_addr | input | 5 | Register byte offset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| irq | output | 1 | Interrupt request |

## Verification
Three situations can only be reached by making two inputs coincide on one edge: a clearing write that lands on the same edge as a new event, a clearing write that targets the flag just being reloaded, and both sources failing together. The stimulus places each strobe and write in the same clock period on purpose. It then reads back the status byte and both capture sets, to show which side won and that the loser's capture set kept its old values. A behavioural model follows every edge and compares `irq` and the currently addressed read byte each cycle.

// File: rtl/ecc_rpt_pkg.sv
package ecc_rpt_pkg;
    typedef enum logic [1:0] {
        FLG_NONE  = 2'd0,
        FLG_RAM   = 2'd1,
        FLG_FLASH = 2'd2
    } flag_state_t;

    localparam int REG_AW       = 5;
    localparam int RAM_POS      = 1;
    localparam int FLASH_POS    = 0;
    localparam logic [7:0] CFG_MASK = 8'h03;
    localparam logic [REG_AW-1:0] OFS_CFG  = 5'h00;
    localparam logic [REG_AW-1:0] OFS_STAT = 5'h01;

    typedef logic [31:0] cap_word_t;
endpackage

// File: rtl/ecc_capture_set.sv
module ecc_capture_set #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int ATTR_W = 8,
    parameter int MID_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] addr,
    input  logic [ATTR_W-1:0] attr,
    input  logic [MID_W-1:0]  mid,
    input  logic [DATA_W-1:0] data,
    output ecc_rpt_pkg::cap_word_t word_addr,
    output ecc_rpt_pkg::cap_word_t word_info,
    output ecc_rpt_pkg::cap_word_t word_data
);
    localparam int MID_LSB = 8;

    ecc_rpt_pkg::cap_word_t addr_d, info_d, data_d;

    always_comb begin
        addr_d = '0;
        info_d = '0;
        data_d = '0;
        addr_d[ADDR_W-1:0]        = addr;
        info_d[ATTR_W-1:0]        = attr;
        info_d[MID_LSB +: MID_W]  = mid;
        data_d[DATA_W-1:0]        = data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_addr <= '0;
            word_info <= '0;
            word_data <= '0;
        end else if (load) begin
            word_addr <= addr_d;
            word_info <= info_d;
            word_data <= data_d;
        end
    end
endmodule

// File: rtl/ecc_flag_fsm.sv
module ecc_flag_fsm
    import ecc_rpt_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ram_ev,
    input  logic        flash_ev,
    input  logic        sw_clear,
    output logic [7:0]  status
);
    flag_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FLG_NONE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLG_NONE: begin
                if (ram_ev)        state_d = FLG_RAM;
                else if (flash_ev) state_d = FLG_FLASH;
            end
            FLG_RAM: begin
                if (ram_ev)        state_d = FLG_RAM;
                else if (flash_ev) state_d = FLG_FLASH;
                else if (sw_clear) state_d = FLG_NONE;
            end
            FLG_FLASH: begin
                if (ram_ev)        state_d = FLG_RAM;
                else if (flash_ev) state_d = FLG_FLASH;
                else if (sw_clear) state_d = FLG_NONE;
            end
            default: state_d = FLG_NONE;
        endcase
    end

    always_comb begin
        status = '0;
        unique case (state_q)
            FLG_RAM:   status[RAM_POS]   = 1'b1;
            FLG_FLASH: status[FLASH_POS] = 1'b1;
            default:   status = '0;
        endcase
    end

    assert_one_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(status));

    assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_clear && !ram_ev && !flash_ev) |=> (status == 8'h00));

    assert_event_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_clear && flash_ev && !ram_ev) |=> (status == 8'h01));
endmodule

// File: rtl/ecc_fault_reporter.sv
module ecc_fault_reporter
    import ecc_rpt_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int ATTR_W = 8,
    parameter int MID_W  = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ram_err_strb,
    input  logic [ADDR_W-1:0]    ram_err_addr,
    input  logic [ATTR_W-1:0]    ram_err_attr,
    input  logic [MID_W-1:0]     ram_err_mid,
    input  logic [DATA_W-1:0]    ram_err_data,
    input  logic                 flash_err_strb,
    input  logic [ADDR_W-1:0]    flash_err_addr,
    input  logic [ATTR_W-1:0]    flash_err_attr,
    input  logic [MID_W-1:0]     flash_err_mid,
    input  logic [DATA_W-1:0]    flash_err_data,
    input  logic [4:0]           reg_addr,
    input  logic                 reg_wr,
    input  logic [7:0]           reg_wdata,
    output logic [7:0]           reg_rdata,
    output logic                 irq
);
    logic [7:0] cfg_q;
    logic [7:0] status;
    logic       ram_ev, flash_ev, sw_clear;
    cap_word_t  ram_a, ram_i, ram_d, fl_a, fl_i, fl_d;
    cap_word_t  rd_word;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cfg_q <= '0;
        else if (reg_wr && reg_addr == OFS_CFG)
            cfg_q <= reg_wdata & CFG_MASK;
    end

    assign ram_ev   = ram_err_strb   && cfg_q[RAM_POS];
    assign flash_ev = flash_err_strb && cfg_q[FLASH_POS];
    assign sw_clear = reg_wr && (reg_addr == OFS_STAT) && ((reg_wdata & status) != 8'h00);

    ecc_flag_fsm u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .ram_ev   (ram_ev),
        .flash_ev (flash_ev),
        .sw_clear (sw_clear),
        .status   (status)
    );

    ecc_capture_set #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ATTR_W(ATTR_W), .MID_W(MID_W)) u_ram_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (ram_ev),
        .addr      (ram_err_addr),
        .attr      (ram_err_attr),
        .mid       (ram_err_mid),
        .data      (ram_err_data),
        .word_addr (ram_a),
        .word_info (ram_i),
        .word_data (ram_d)
    );

    ecc_capture_set #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ATTR_W(ATTR_W), .MID_W(MID_W)) u_flash_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (flash_ev && !ram_ev),
        .addr      (flash_err_addr),
        .attr      (flash_err_attr),
        .mid       (flash_err_mid),
        .data      (flash_err_data),
        .word_addr (fl_a),
        .word_info (fl_i),
        .word_data (fl_d)
    );

    assign irq = (cfg_q[RAM_POS] && status[RAM_POS]) || (cfg_q[FLASH_POS] && status[FLASH_POS]);

    always_comb begin
        unique case (reg_addr[4:2])
            3'd0:    rd_word = {16'h0000, status, cfg_q};
            3'd1:    rd_word = ram_a;
            3'd2:    rd_word = ram_i;
            3'd3:    rd_word = ram_d;
            3'd5:    rd_word = fl_a;
            3'd6:    rd_word = fl_i;
            3'd7:    rd_word = fl_d;
            default: rd_word = '0;
        endcase
        reg_rdata = rd_word[{reg_addr[1:0], 3'b000} +: 8];
    end

    assert_ram_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_err_strb && cfg_q[RAM_POS]) |=> (status == 8'h02));

    assert_disabled_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_err_strb && !cfg_q[RAM_POS]) |=> ($stable(ram_a) && $stable(ram_d)));

    assert_irq_needs_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (status != 8'h00));

    assert_ram_priority_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_ev && flash_ev) |=> ($stable(fl_a) && $stable(fl_d) && status == 8'h02));
endmodule

// File: tb/sim_ecc_fault_reporter.sv
`timescale 1ns/100ps
module sim_ecc_fault_reporter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ram_err_strb = 1'b0, flash_err_strb = 1'b0;
    logic [31:0] ram_err_addr = '0, ram_err_data = '0, flash_err_addr = '0, flash_err_data = '0;
    logic [7:0]  ram_err_attr = '0, flash_err_attr = '0;
    logic [3:0]  ram_err_mid = '0, flash_err_mid = '0;
    logic [4:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    ecc_fault_reporter u0 (
        .clk(clk), .rst_n(rst_n),
        .ram_err_strb(ram_err_strb), .ram_err_addr(ram_err_addr), .ram_err_attr(ram_err_attr),
        .ram_err_mid(ram_err_mid), .ram_err_data(ram_err_data),
        .flash_err_strb(flash_err_strb), .flash_err_addr(flash_err_addr), .flash_err_attr(flash_err_attr),
        .flash_err_mid(flash_err_mid), .flash_err_data(flash_err_data),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    // behavioural reference model
    logic [7:0]  m_cfg, m_stat;
    logic [31:0] m_word [0:7];
    bit          m_rev, m_fev, m_clr;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cfg = 0; m_stat = 0;
            for (int i = 0; i < 8; i++) m_word[i] = 0;
        end else begin
            m_rev = ram_err_strb && m_cfg[1];
            m_fev = flash_err_strb && m_cfg[0];
            m_clr = reg_wr && reg_addr == 5'h01 && ((reg_wdata & m_stat) != 0);
            if (m_rev) begin
                m_stat = 8'h02;
                m_word[1] = ram_err_addr;
                m_word[2] = {20'h0, ram_err_mid, ram_err_attr};
                m_word[3] = ram_err_data;
            end else if (m_fev) begin
                m_stat = 8'h01;
                m_word[5] = flash_err_addr;
                m_word[6] = {20'h0, flash_err_mid, flash_err_attr};
                m_word[7] = flash_err_data;
            end else if (m_clr) begin
                m_stat = 8'h00;
            end
            if (reg_wr && reg_addr == 5'h00) m_cfg = reg_wdata & 8'h03;
        end
    end

    function automatic logic [7:0] model_byte(input logic [4:0] a);
        logic [31:0] w;
        w = (a[4:2] == 0) ? {16'h0, m_stat, m_cfg} : m_word[a[4:2]];
        return w[a[1:0]*8 +: 8];
    endfunction

    // per-clock comparison against the model (R6 irq, R10 read path)
    always @(negedge clk) begin
        if (rst_n) begin
            checks++;
            if (irq !== ((m_cfg[1] && m_stat[1]) || (m_cfg[0] && m_stat[0]))) begin
                errors++;
                $display("FAIL R6 per-clock irq: got %b exp %b", irq, (m_cfg[1] && m_stat[1]) || (m_cfg[0] && m_stat[0]));
            end
            checks++;
            if (reg_rdata !== model_byte(reg_addr)) begin
                errors++;
                $display("FAIL R10 per-clock read @%h: got %h exp %h", reg_addr, reg_rdata, model_byte(reg_addr));
            end
        end
    end

    task automatic step(input bit rs, input bit fs, input bit wr, input logic [4:0] a, input logic [7:0] d);
        @(negedge clk); #0.5;
        ram_err_strb = rs; flash_err_strb = fs; reg_wr = wr; reg_addr = a; reg_wdata = d;
        @(posedge clk); #0.5;
        ram_err_strb = 0; flash_err_strb = 0; reg_wr = 0;
    endtask

    task automatic wr_reg(input logic [4:0] a, input logic [7:0] d);
        step(0, 0, 1, a, d);
    endtask

    task automatic chk(input logic [4:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk); #0.5;
        reg_addr = a; #0.5;
        checks++;
        if (reg_rdata !== exp) begin
            errors++;
            $display("FAIL %s read @%h: got %h exp %h", tag, a, reg_rdata, exp);
        end
    endtask

    task automatic chk_word(input logic [4:0] base, input logic [31:0] exp, input string tag);
        for (int b = 0; b < 4; b++) chk(base + 5'(b), exp[b*8 +: 8], tag);
    endtask

    task automatic chk_irq(input logic exp, input string tag);
        @(negedge clk); #1;
        checks++;
        if (irq !== exp) begin
            errors++;
            $display("FAIL %s irq: got %b exp %b", tag, irq, exp);
        end
    endtask

    task automatic set_ram(input logic [31:0] a, input logic [7:0] at, input logic [3:0] m, input logic [31:0] d);
        ram_err_addr = a; ram_err_attr = at; ram_err_mid = m; ram_err_data = d;
    endtask

    task automatic set_flash(input logic [31:0] a, input logic [7:0] at, input logic [3:0] m, input logic [31:0] d);
        flash_err_addr = a; flash_err_attr = at; flash_err_mid = m; flash_err_data = d;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout exp completion");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #0.5 rst_n = 1'b1;

        // R1 reset state
        chk(5'h00, 8'h00, "R1");
        chk(5'h01, 8'h00, "R1");
        chk_irq(1'b0, "R1");
        chk_word(5'h04, 32'h0, "R1");
        chk_word(5'h1C, 32'h0, "R1");

        // R2 reserved bits drop
        wr_reg(5'h00, 8'hFF);
        chk(5'h00, 8'h03, "R2");

        // R3 RAM event, R10 layout
        set_ram(32'h1234_5678, 8'h5A, 4'h3, 32'hDEAD_BEEF);
        step(1, 0, 0, 5'h01, 8'h00);
        chk(5'h01, 8'h02, "R3");
        chk_irq(1'b1, "R6");
        chk_word(5'h04, 32'h1234_5678, "R3");
        chk_word(5'h08, 32'h0000_035A, "R10");
        chk_word(5'h0C, 32'hDEAD_BEEF, "R3");

        // R4 newer flash event replaces RAM flag
        set_flash(32'h0BAD_F00D, 8'hC3, 4'hA, 32'h0102_0304);
        step(0, 1, 0, 5'h01, 8'h00);
        chk(5'h01, 8'h01, "R4");
        chk_word(5'h14, 32'h0BAD_F00D, "R3");
        chk_word(5'h18, 32'h0000_0AC3, "R10");
        chk_word(5'h1C, 32'h0102_0304, "R3");
        chk_word(5'h04, 32'h1234_5678, "R3");

        // R7 write-1-to-clear
        wr_reg(5'h01, 8'h02);
        chk(5'h01, 8'h01, "R7");
        wr_reg(5'h01, 8'h00);
        chk(5'h01, 8'h01, "R7");
        wr_reg(5'h01, 8'h01);
        chk(5'h01, 8'h00, "R7");
        chk_irq(1'b0, "R7");

        // R10 capture registers read-only
        wr_reg(5'h04, 8'hAA);
        chk(5'h04, 8'h78, "R10");

        // R5 disabled sources
        wr_reg(5'h00, 8'h02);
        set_flash(32'h5555_6666, 8'h11, 4'h1, 32'hCAFE_0001);
        step(0, 1, 0, 5'h01, 8'h00);
        chk(5'h01, 8'h00, "R5");
        chk_word(5'h14, 32'h0BAD_F00D, "R5");
        wr_reg(5'h00, 8'h00);
        set_ram(32'h7777_8888, 8'h22, 4'h7, 32'hCAFE_0002);
        step(1, 0, 0, 5'h01, 8'h00);
        chk(5'h01, 8'h00, "R5");
        chk_word(5'h04, 32'h1234_5678, "R5");
        chk_irq(1'b0, "R5");

        // R8 simultaneous events: RAM wins
        wr_reg(5'h00, 8'h03);
        step(1, 1, 0, 5'h01, 8'h00);
        chk(5'h01, 8'h02, "R8");
        chk_word(5'h04, 32'h7777_8888, "R8");
        chk_word(5'h14, 32'h0BAD_F00D, "R8");

        // R9 event coinciding with clear
        step(0, 1, 1, 5'h01, 8'h02);
        chk(5'h01, 8'h01, "R9");
        chk_word(5'h14, 32'h5555_6666, "R9");
        step(0, 1, 1, 5'h01, 8'h01);
        chk(5'h01, 8'h01, "R9");

        // R6 irq follows enable AND flag
        wr_reg(5'h00, 8'h02);
        chk_irq(1'b0, "R6");
        chk(5'h01, 8'h01, "R6");
        wr_reg(5'h00, 8'h01);
        chk_irq(1'b1, "R6");
        wr_reg(5'h01, 8'h01);
        chk_irq(1'b0, "R7");

        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule